// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Interface

This block is the host-facing front end of a display controller. An 8-bit microprocessor bus reaches it through a chip select, an address line (`a0`) and two strobe pins. A static strap selects how the strobes are read. In 6800 style they are an enable and a read/write line. In 8080 style they are separate active-low read and write strobes. The block resolves every bus cycle into one of four transfers: display data read, display data write, status read or instruction write.

All host pins are brought into the system clock domain through a synchroniser chain. The end of a strobe marks a completed transfer. A write then leaves the block as a one-cycle pulse with a type flag and the captured byte. A display data read is served from a prefetch register, so the first read after reset is a dummy read. Each completed display read refills that register from the core and pulses an increment request toward the address counter. The bus output enable is decoded straight from the pins, so the pad drives only while a valid read is in progress. In 6800 style the enable pin may be tied high. Chip select then acts as the strobe, and its rising edge completes the transfer.

Top module: `hbp_par_if`

## Requirements
- R1: While `cs_n` is high, `bus_oe` stays 0 and no `wr_pulse` or `rd_inc` is produced, whatever the levels of `a0`, `strb_a` and `strb_b`.
- R2: `mode_i8080` = 0 selects 6800 style (`strb_a` = enable E, `strb_b` = read/write R/W). `mode_i8080` = 1 selects 8080 style (`strb_a` = /RD, `strb_b` = /WR). The same pin levels are therefore read differently in the two modes.
- R3: `a0` = 1 marks display data and `a0` = 0 marks register access. A write reports `wr_is_data` equal to `a0`. A read with `a0` = 0 drives `status_in` onto `bus_out`.
- R4: In 6800 style with E pulsed, R/W = 1 and E = 1 with `cs_n` low drive the bus. With R/W = 0, the byte on `bus_in` while E is high is delivered once after E falls.
- R5: In 8080 style, /RD = 0 with /WR = 1 and `cs_n` low drive the bus. With /RD = 1 and /WR = 0, the byte on `bus_in` is delivered once after /WR rises.
- R6: In 6800 style with E held at 1, `cs_n` going high completes the transfer. Its type comes from `a0` and R/W, and a write delivers the byte that was present while `cs_n` was low.
- R7: In 8080 style, /RD and /WR low together neither drive the bus nor produce any write or read-completion pulse.
- R8: A display data read returns the byte loaded by the previous display read, or 0 for the first read after reset. Each completed display read produces exactly one `rd_inc` pulse, and a status read produces none.
- R9: `bus_oe` is 1 only while `cs_n` is low and a read is being signalled. A write cycle never drives the bus.
- R10: Every completed write gives exactly one single-cycle `wr_pulse`. `wr_data` and `wr_is_data` hold their values until the next write.
- R11: After reset, `bus_oe`, `wr_pulse` and `rd_inc` are 0 and the prefetch value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i8080 | input | 1 | Bus style strap: 0 = 6800, 1 = 8080 |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | 1 = display data, 0 = instruction/status |
| strb_a | input | 1 | E (6800) or /RD (8080) |
| strb_b | input | 1 | R/W (6800) or /WR (8080) |
| bus_in | input | DATA_W | Data bus input from the pad |
| bus_out | output | DATA_W | Data bus value to drive |
| bus_oe | output | 1 | Pad output enable |
| status_in | input | DATA_W | Internal status byte |
| disp_rd_data | input | DATA_W | Display byte at the current address |
| wr_pulse | output | 1 | One-cycle write strobe to the core |
| wr_is_data | output | 1 | 1 = display data write, 0 = instruction |
| wr_data | output | DATA_W | Captured write byte |
| rd_inc | output | 1 | One-cycle address increment request after a display read |

## Verification
Writes and reads are swept over both bus styles, both E variants of 6800 style, both values of `a0`, and bytes with all-zero, all-one, alternating and walking-one patterns. This separates the type decode from the data path and exposes stuck or swapped data bits. All eight pin combinations are replayed with chip select high, and the 8080 double-low strobe pattern is applied, to show that these cycles leave no trace. A chain of display reads against an arithmetic memory model shows the one-deep prefetch: the first read returns zero, each later read returns the value fetched by the read before it, and status reads interleaved in the chain do not advance the address.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

   // Host control pins as seen after synchronisation
   typedef struct packed {
      logic cs_n;
      logic a0;
      logic stb_a;   // E or /RD
      logic stb_b;   // R/W or /WR
   } ctl_t;

   localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, a0: 1'b1, stb_a: 1'b1, stb_b: 1'b1};

   // 6800 style: a cycle is open while selected with E high
   function automatic logic m68_open(ctl_t c);
      return !c.cs_n && c.stb_a;
   endfunction

   // 8080 style: exclusive read strobe
   function automatic logic i80_rd_open(ctl_t c);
      return !c.cs_n && !c.stb_a && c.stb_b;
   endfunction

   // 8080 style: exclusive write strobe
   function automatic logic i80_wr_open(ctl_t c);
      return !c.cs_n && c.stb_a && !c.stb_b;
   endfunction

endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/hbp_decode.sv
module hbp_decode
   import hbp_pkg::*;
(
   input  logic mode_i8080,
   input  ctl_t cur,
   input  ctl_t prev,
   output logic rd_evt,
   output logic wr_evt,
   output logic evt_is_data
);

   logic m68_end;
   logic i80_rd_end;
   logic i80_wr_end;

   // A transfer completes on the sample where its open condition drops.
   // In 6800 style this covers both E falling and chip select rising
   // while E is held high.
   assign m68_end    = m68_open(prev)    && !m68_open(cur);
   assign i80_rd_end = i80_rd_open(prev) && !i80_rd_open(cur);
   assign i80_wr_end = i80_wr_open(prev) && !i80_wr_open(cur);

   always_comb begin
      if (mode_i8080) begin
         rd_evt = i80_rd_end;
         wr_evt = i80_wr_end;
      end else begin
         rd_evt = m68_end &&  prev.stb_b;
         wr_evt = m68_end && !prev.stb_b;
      end
      evt_is_data = prev.a0;
   end

endmodule

// File: rtl/hbp_xfer.sv
module hbp_xfer #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_evt,
   input  logic              wr_evt,
   input  logic              evt_is_data,
   input  logic [DATA_W-1:0] cap_data,
   input  logic [DATA_W-1:0] disp_rd_data,
   output logic              wr_pulse,
   output logic              wr_is_data,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_inc,
   output logic [DATA_W-1:0] prefetch
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pulse   <= 1'b0;
         wr_is_data <= 1'b0;
         wr_data    <= '0;
      end else begin
         wr_pulse <= wr_evt;
         if (wr_evt) begin
            wr_is_data <= evt_is_data;
            wr_data    <= cap_data;
         end
      end
   end

   // One-deep read-ahead: a finished display read refills the buffer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_inc   <= 1'b0;
         prefetch <= '0;
      end else begin
         rd_inc <= rd_evt && evt_is_data;
         if (rd_evt && evt_is_data) prefetch <= disp_rd_data;
      end
   end

endmodule

// File: rtl/hbp_rdmux.sv
module hbp_rdmux #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              mode_i8080,
   input  logic              cs_n,
   input  logic              a0,
   input  logic              strb_a,
   input  logic              strb_b,
   input  logic [DATA_W-1:0] prefetch,
   input  logic [DATA_W-1:0] status_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe
);

   logic rd_m68;
   logic rd_i80;

   // Decoded straight from the pins so the pad turns on and off with
   // the host strobe rather than with the synchronised copy.
   assign rd_m68 = !mode_i8080 && !cs_n &&  strb_a && strb_b;
   assign rd_i80 =  mode_i8080 && !cs_n && !strb_a && strb_b;
   assign bus_oe = rd_m68 || rd_i80;

   always_comb begin
      if (!bus_oe)  bus_out = '0;
      else if (a0)  bus_out = prefetch;
      else          bus_out = status_in;
   end

endmodule

// File: rtl/hbp_par_if.sv
module hbp_par_if
   import hbp_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_i8080,
   input  logic              cs_n,
   input  logic              a0,
   input  logic              strb_a,
   input  logic              strb_b,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] status_in,
   input  logic [DATA_W-1:0] disp_rd_data,
   output logic              wr_pulse,
   output logic              wr_is_data,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_inc
);

   localparam int unsigned CTL_W = $bits(ctl_t);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("hbp_par_if: SYNC_STAGES must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("hbp_par_if: DATA_W must be at least 1");
      end
   endgenerate

   ctl_t              ctl_raw;
   ctl_t              ctl_s;
   ctl_t              ctl_q;
   logic [DATA_W-1:0] dat_s;
   logic [DATA_W-1:0] dat_q;
   logic              rd_evt;
   logic              wr_evt;
   logic              evt_is_data;
   logic [DATA_W-1:0] prefetch;

   assign ctl_raw = '{cs_n: cs_n, a0: a0, stb_a: strb_a, stb_b: strb_b};

   hbp_sync #(
      .W       (CTL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CTL_IDLE)
   ) u_sync_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s)
   );

   hbp_sync #(
      .W       (DATA_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('0)
   ) u_sync_dat (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_in),
      .q     (dat_s)
   );

   // One more sample so that a falling open condition can be seen
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_IDLE;
         dat_q <= '0;
      end else begin
         ctl_q <= ctl_s;
         dat_q <= dat_s;
      end
   end

   hbp_decode u_decode (
      .mode_i8080  (mode_i8080),
      .cur         (ctl_s),
      .prev        (ctl_q),
      .rd_evt      (rd_evt),
      .wr_evt      (wr_evt),
      .evt_is_data (evt_is_data)
   );

   hbp_xfer #(.DATA_W(DATA_W)) u_xfer (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_evt       (rd_evt),
      .wr_evt       (wr_evt),
      .evt_is_data  (evt_is_data),
      .cap_data     (dat_q),
      .disp_rd_data (disp_rd_data),
      .wr_pulse     (wr_pulse),
      .wr_is_data   (wr_is_data),
      .wr_data      (wr_data),
      .rd_inc       (rd_inc),
      .prefetch     (prefetch)
   );

   hbp_rdmux #(.DATA_W(DATA_W)) u_rdmux (
      .mode_i8080 (mode_i8080),
      .cs_n       (cs_n),
      .a0         (a0),
      .strb_a     (strb_a),
      .strb_b     (strb_b),
      .prefetch   (prefetch),
      .status_in  (status_in),
      .bus_out    (bus_out),
      .bus_oe     (bus_oe)
   );

endmodule

// File: rtl/hbp_chk.sv
module hbp_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_i8080,
   input logic              cs_n,
   input logic              strb_a,
   input logic              strb_b,
   input logic              bus_oe,
   input logic              wr_pulse,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_is_data,
   input logic              rd_inc
);

   a_r1_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !bus_oe);

   a_r7_double_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i8080 && !strb_a && !strb_b) |-> !bus_oe);

   a_r9_m68_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i8080 && !strb_b) |-> !bus_oe);

   a_r10_single_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse);

   a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pulse |-> ($stable(wr_data) && $stable(wr_is_data)));

   a_r8_single_inc: assert property (@(posedge clk) disable iff (!rst_n)
      rd_inc |=> !rd_inc);

   a_r8_inc_not_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      rd_inc |-> !wr_pulse);

endmodule

bind hbp_par_if hbp_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_i8080 (mode_i8080),
   .cs_n       (cs_n),
   .strb_a     (strb_a),
   .strb_b     (strb_b),
   .bus_oe     (bus_oe),
   .wr_pulse   (wr_pulse),
   .wr_data    (wr_data),
   .wr_is_data (wr_is_data),
   .rd_inc     (rd_inc)
);

// File: tb/sim_hbp_par_if.sv
`timescale 1ns/1ps
module sim_hbp_par_if;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_i8080 = 1'b0;
   logic          cs_n = 1'b1;
   logic          a0 = 1'b1;
   logic          strb_a = 1'b0;
   logic          strb_b = 1'b1;
   logic [DW-1:0] bus_in = '0;
   logic [DW-1:0] bus_out;
   logic          bus_oe;
   logic [DW-1:0] status_in = '0;
   logic [DW-1:0] disp_rd_data;
   logic          wr_pulse;
   logic          wr_is_data;
   logic [DW-1:0] wr_data;
   logic          rd_inc;

   int errors = 0;
   int checks = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   int addr_model = 0;
   int n_dreads = 0;
   logic [DW-1:0] exp_pref = '0;

   always #2 clk = ~clk;

   function automatic logic [DW-1:0] mem_f(int a);
      return DW'(a * 37 + 5);
   endfunction

   assign disp_rd_data = mem_f(addr_model);

   hbp_par_if #(.DATA_W(DW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_i8080(mode_i8080), .cs_n(cs_n), .a0(a0),
      .strb_a(strb_a), .strb_b(strb_b), .bus_in(bus_in), .bus_out(bus_out),
      .bus_oe(bus_oe), .status_in(status_in), .disp_rd_data(disp_rd_data),
      .wr_pulse(wr_pulse), .wr_is_data(wr_is_data), .wr_data(wr_data), .rd_inc(rd_inc)
   );

   always @(negedge clk) begin
      if (wr_pulse) wr_cnt <= wr_cnt + 1;
      if (rd_inc) begin
         rd_cnt     <= rd_cnt + 1;
         addr_model <= addr_model + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // m: 1 = 8080 style; c: 6800 with E held high (chip select strobes)
   task automatic set_idle(input bit m, input bit c);
      cs_n = 1'b1;
      if (m) begin strb_a = 1'b1; strb_b = 1'b1; end
      else   begin strb_a = c;    strb_b = 1'b1; end
   endtask

   task automatic do_write(input bit m, input bit c, input bit a, input logic [DW-1:0] d);
      int w0;
      w0 = wr_cnt;
      @(negedge clk);
      mode_i8080 = m; set_idle(m, c);
      a0 = a; bus_in = d;
      if (!m) strb_b = 1'b0;
      wait_n(2);
      cs_n = 1'b0;
      wait_n(2);
      if (m) begin
         strb_b = 1'b0; wait_n(3);
         #1 chk(bus_oe == 1'b0, "R9 write no drive", bus_oe, 0);
         wait_n(1);
         strb_b = 1'b1; wait_n(2);
      end else if (!c) begin
         strb_a = 1'b1; wait_n(3);
         #1 chk(bus_oe == 1'b0, "R9 write no drive", bus_oe, 0);
         wait_n(1);
         strb_a = 1'b0; wait_n(2);
      end else begin
         wait_n(3);
         #1 chk(bus_oe == 1'b0, "R9 write no drive", bus_oe, 0);
         wait_n(1);
      end
      cs_n = 1'b1;
      wait_n(8);
      chk(wr_cnt == w0 + 1, m ? "R5 one write" : (c ? "R6 one write" : "R4 one write"), wr_cnt - w0, 1);
      chk(wr_data == d, m ? "R5 data" : (c ? "R6 data" : "R4 data"), wr_data, d);
      chk(wr_is_data == a, "R3 write kind", wr_is_data, a);
      set_idle(m, c);
      bus_in = ~d;
      wait_n(2);
      chk(wr_data == d && wr_cnt == w0 + 1, "R10 hold", wr_data, d);
   endtask

   task automatic do_read(input bit m, input bit c, input bit a);
      int r0;
      logic [DW-1:0] exp;
      r0 = rd_cnt;
      exp = a ? exp_pref : status_in;
      @(negedge clk);
      mode_i8080 = m; set_idle(m, c);
      a0 = a;
      wait_n(2);
      cs_n = 1'b0;
      if (m) strb_a = 1'b0;
      else if (!c) strb_a = 1'b1;
      wait_n(3);
      #1;
      chk(bus_oe == 1'b1, m ? "R5 read drive" : (c ? "R6 read drive" : "R4 read drive"), bus_oe, 1);
      chk(bus_out == exp, a ? "R8 data read" : "R3 status read", bus_out, exp);
      wait_n(1);
      if (m) strb_a = 1'b1;
      else if (!c) strb_a = 1'b0;
      else cs_n = 1'b1;
      #1 chk(bus_oe == 1'b0, "R9 release", bus_oe, 0);
      wait_n(1);
      cs_n = 1'b1;
      wait_n(8);
      if (a) begin
         exp_pref = mem_f(n_dreads);
         n_dreads++;
         chk(rd_cnt == r0 + 1, "R8 one inc", rd_cnt - r0, 1);
      end else begin
         chk(rd_cnt == r0, "R8 no inc on status", rd_cnt - r0, 0);
      end
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [DW-1:0] pats [6];
      int w0, r0;
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
      pats[3] = 8'h5A; pats[4] = 8'h01; pats[5] = 8'h80;

      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      #1;
      chk(bus_oe == 1'b0, "R11 oe", bus_oe, 0);
      chk(wr_pulse == 1'b0, "R11 wr_pulse", wr_pulse, 0);
      chk(rd_inc == 1'b0, "R11 rd_inc", rd_inc, 0);

      // R11/R8: first display read is the dummy zero
      do_read(1'b1, 1'b0, 1'b1);

      // R1: every pin combination ignored while deselected
      w0 = wr_cnt; r0 = rd_cnt;
      for (int m = 0; m < 2; m++) begin
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            mode_i8080 = m[0]; cs_n = 1'b1;
            a0 = k[2]; strb_a = k[1]; strb_b = k[0];
            wait_n(3);
            #1 chk(bus_oe == 1'b0, "R1 deselected drive", bus_oe, 0);
         end
      end
      set_idle(1'b1, 1'b0);
      wait_n(6);
      chk(wr_cnt == w0 && rd_cnt == r0, "R1 no pulses", wr_cnt - w0, 0);

      // R2: 8080 read levels mean E low in 6800 style
      @(negedge clk);
      mode_i8080 = 1'b0; cs_n = 1'b0; strb_a = 1'b0; strb_b = 1'b1;
      wait_n(2);
      #1 chk(bus_oe == 1'b0, "R2 6800 no drive", bus_oe, 0);
      mode_i8080 = 1'b1;
      #1 chk(bus_oe == 1'b1, "R2 8080 drive", bus_oe, 1);
      mode_i8080 = 1'b0;
      wait_n(1);
      cs_n = 1'b1;
      wait_n(6);

      // R7: double-low strobe in 8080 style
      w0 = wr_cnt; r0 = rd_cnt;
      @(negedge clk);
      mode_i8080 = 1'b1; set_idle(1'b1, 1'b0); a0 = 1'b1; bus_in = 8'h3C;
      wait_n(2);
      cs_n = 1'b0; wait_n(2);
      strb_a = 1'b0; strb_b = 1'b0; wait_n(4);
      #1 chk(bus_oe == 1'b0, "R7 no drive", bus_oe, 0);
      wait_n(1);
      strb_a = 1'b1; strb_b = 1'b1; wait_n(2);
      cs_n = 1'b1; wait_n(8);
      chk(wr_cnt == w0 && rd_cnt == r0, "R7 no pulses", (wr_cnt - w0) + (rd_cnt - r0), 0);

      // Write sweep over styles, kinds and bit patterns (R3 R4 R5 R6 R10)
      for (int v = 0; v < 3; v++) begin
         for (int a = 0; a < 2; a++) begin
            for (int p = 0; p < 6; p++) begin
               do_write(v == 2, v == 1, a[0], pats[p] ^ DW'(v));
            end
         end
      end

      // Read sweep: status and display reads in every style (R3 R4 R5 R6 R8)
      for (int v = 0; v < 3; v++) begin
         for (int p = 0; p < 3; p++) begin
            status_in = pats[p + v];
            do_read(v == 2, v == 1, 1'b0);
            do_read(v == 2, v == 1, 1'b1);
            do_read(v == 2, v == 1, 1'b1);
         end
      end

      wait_n(4);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule